// File: doc/BRIEF.md
# Receiver Status Flag Unit

This block holds the word delivered by a serial receiver's shift register, together with three status flags: received-data-full, idle-line and overrun. It also drives one interrupt request. A frame-complete strobe from the shift register loads the held word. A bit-rate sample strobe with the line level feeds an idle detector. A one-strobe bus read port returns either the status byte or the low byte of the held word.

Flags are cleared by a two-step bus sequence. A status read takes a snapshot of the flags. The data read that follows clears only the flags in that snapshot. After a valid frame, the idle detector reports one idle run. Receiver wakeup mode suppresses it. It then stays disarmed until the next frame is accepted. A frame that arrives while the held word is still unread is discarded and raises overrun.

Top module: `rx_flag_unit`

## Requirements
- R1: After reset, data_full, idle_flag, overrun and irq are 0 and held_data is 0.
- R2: A frame_stb while data_full is 0 loads frame_data into held_data and sets data_full.
- R3: A read with rd_sel=0 returns the status byte, with bit 2 = data_full, bit 1 = idle_flag, bit 0 = overrun and the upper bits 0. It also records which flags are set. The next read with rd_sel=1 returns held_data[7:0] and clears exactly the recorded flags. A flag set between the two reads stays set.
- R4: A read with rd_sel=1 that does not follow a status read returns held_data[7:0] and leaves every flag unchanged.
- R5: idle_flag sets on the bit_tick sample that completes 10 consecutive rx_line=1 samples when fmt9=0, or 11 when fmt9=1. An rx_line=0 sample restarts the count, and one unbroken run sets the flag at most once.
- R6: While wake_en is 1, an idle run does not set idle_flag.
- R7: After reset, and after idle_flag has been set, idle detection stays disarmed until a frame loads held_data.
- R8: A frame_stb while data_full is 1 sets overrun, discards the frame and leaves held_data unchanged.
- R9: irq is a register. It follows, one clock later, ((data_full or overrun) and rie) or (idle_flag and ilie).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | Frame complete from shift register |
| frame_data | input | 9 | Received word |
| bit_tick | input | 1 | Bit-rate sample strobe |
| rx_line | input | 1 | Serial input level at the sample |
| rd_stb | input | 1 | Bus read strobe, one cycle |
| rd_sel | input | 1 | 0 = status byte, 1 = low data byte |
| rd_data | output | 8 | Read data, valid while rd_stb is high |
| fmt9 | input | 1 | 1 selects 9-bit data format |
| wake_en | input | 1 | Receiver wakeup mode |
| rie | input | 1 | Data/overrun interrupt enable |
| ilie | input | 1 | Idle interrupt enable |
| data_full | output | 1 | Received data available |
| idle_flag | output | 1 | Idle line seen |
| overrun | output | 1 | Frame lost to unread data |
| held_data | output | 9 | Held received word |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that frame_stb and rd_stb are single-cycle strobes and never both high in the same cycle. The overrun property also assumes that no read coincides with a frame arriving on a full register. The stimulus drives each strobe for one clock at a time from separate sequential tasks, and each task ends before the next begins, so no two strobes overlap. The bench changes wake_en, fmt9 and the enables only between operations, never during a read pair or an idle run it is measuring.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
    typedef struct packed {
        logic full;
        logic idle;
        logic ovr;
    } rxf_flags_t;

    localparam logic RD_STATUS = 1'b0;
    localparam logic RD_DATA   = 1'b1;
endpackage

// File: rtl/rxf_idle_det.sv
`timescale 1ns/1ps
module rxf_idle_det #(
    parameter int LIM_SHORT = 10,
    parameter int LIM_LONG  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic long_fmt,
    output logic idle_evt
);
    localparam int CW = $clog2(LIM_LONG + 1);
    localparam logic [CW-1:0] LIM_S = CW'(LIM_SHORT);
    localparam logic [CW-1:0] LIM_L = CW'(LIM_LONG);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        st_d     = st_q;
        idle_evt = 1'b0;
        lim      = long_fmt ? LIM_L : LIM_S;
        if (tick) begin
            if (!line) begin
                st_d.cnt = '0;
            end else if (st_q.cnt < lim) begin
                st_d.cnt = st_q.cnt + 1'b1;
                idle_evt = (st_q.cnt + 1'b1) == lim;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: the run counter saturates at the longer limit
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIM_L);
    // R5: one event per unbroken run
    p_one_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt && !$changed(long_fmt) |=> !idle_evt || $past(!line));
endmodule

// File: rtl/rxf_clr_seq.sv
`timescale 1ns/1ps
module rxf_clr_seq
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_stb,
    input  logic       rd_sel,
    input  rxf_flags_t flags_i,
    output rxf_flags_t clr_o
);
    typedef struct packed {
        logic       armed;
        rxf_flags_t snap;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (rd_stb) begin
            if (rd_sel == RD_STATUS) begin
                st_d.armed = 1'b1;
                st_d.snap  = flags_i;
            end else begin
                if (st_q.armed) clr_o = st_q.snap;
                st_d.armed = 1'b0;
                st_d.snap  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a clear only ever targets flags that are currently set
    p_clr_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o & ~flags_i) == '0);
endmodule

// File: rtl/rx_flag_unit.sv
`timescale 1ns/1ps
module rx_flag_unit
    import rxf_pkg::*;
#(
    parameter int DW         = 9,
    parameter int RW         = 8,
    parameter int IDLE_SHORT = 10,
    parameter int IDLE_LONG  = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic [DW-1:0] frame_data,
    input  logic          bit_tick,
    input  logic          rx_line,
    input  logic          rd_stb,
    input  logic          rd_sel,
    output logic [RW-1:0] rd_data,
    input  logic          fmt9,
    input  logic          wake_en,
    input  logic          rie,
    input  logic          ilie,
    output logic          data_full,
    output logic          idle_flag,
    output logic          overrun,
    output logic [DW-1:0] held_data,
    output logic          irq
);
    typedef struct packed {
        rxf_flags_t    fl;
        logic [DW-1:0] data;
        logic          arm;
        logic          irq;
    } st_t;

    st_t        st_d, st_q;
    rxf_flags_t clr;
    logic       idle_evt;

    rxf_idle_det #(.LIM_SHORT(IDLE_SHORT), .LIM_LONG(IDLE_LONG)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .line     (rx_line),
        .long_fmt (fmt9),
        .idle_evt (idle_evt)
    );

    rxf_clr_seq u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_sel  (rd_sel),
        .flags_i (st_q.fl),
        .clr_o   (clr)
    );

    always_comb begin
        st_d    = st_q;
        st_d.fl = st_q.fl & ~clr;
        if (idle_evt && st_q.arm && !wake_en) begin
            st_d.fl.idle = 1'b1;
            st_d.arm     = 1'b0;
        end
        if (frame_stb) begin
            if (st_d.fl.full) begin
                st_d.fl.ovr = 1'b1;
            end else begin
                st_d.data    = frame_data;
                st_d.fl.full = 1'b1;
                st_d.arm     = 1'b1;
            end
        end
        st_d.irq = ((st_q.fl.full | st_q.fl.ovr) & rie) | (st_q.fl.idle & ilie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == RD_STATUS) rd_data[2:0] = {st_q.fl.full, st_q.fl.idle, st_q.fl.ovr};
        else                     rd_data      = st_q.data[RW-1:0];
    end

    assign data_full = st_q.fl.full;
    assign idle_flag = st_q.fl.idle;
    assign overrun   = st_q.fl.ovr;
    assign held_data = st_q.data;
    assign irq       = st_q.irq;

    // R2: a frame into an empty register is captured and flagged
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && !data_full |=> data_full && held_data == $past(frame_data));
    // R8: a frame onto unread data raises overrun and keeps the held word
    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && data_full && !rd_stb |=> overrun && $stable(held_data));
    // R8: the held word changes only after a frame strobe
    p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(held_data));
    // R6: idle never rises out of a cycle with wakeup mode on
    p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> !$past(wake_en));
    // R3: any flag falls only after a data read
    p_clear_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_full) || $fell(overrun) || $fell(idle_flag) |->
        $past(rd_stb && rd_sel == RD_DATA));
    // R9: a held, enabled data flag keeps the request asserted
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_full && rie && $past(data_full && rie) |-> irq);
endmodule

// File: tb/rx_flag_unit_test.sv
`timescale 1ns/1ps
module rx_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic [8:0] frame_data = '0;
    logic       bit_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       rd_stb = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       fmt9 = 1'b0, wake_en = 1'b0, rie = 1'b1, ilie = 1'b0;
    logic       data_full, idle_flag, overrun, irq;
    logic [8:0] held_data;

    always #2 clk = ~clk;

    rx_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_data(frame_data),
        .bit_tick(bit_tick), .rx_line(rx_line), .rd_stb(rd_stb), .rd_sel(rd_sel),
        .rd_data(rd_data), .fmt9(fmt9), .wake_en(wake_en), .rie(rie), .ilie(ilie),
        .data_full(data_full), .idle_flag(idle_flag), .overrun(overrun),
        .held_data(held_data), .irq(irq)
    );

    typedef struct packed {
        logic       is_rd;
        logic [7:0] req;
        logic       full, idle, ovr;
        logic [8:0] data;
        logic       irq;
        logic [7:0] rd;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // monitor: pops each expected item and compares one ns later
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() > 0);
            #1;
            e = exp_q.pop_front();
            checks++;
            if (e.is_rd) begin
                if (rd_data !== e.rd) begin
                    errors++;
                    $display("FAIL R%0d rd_data actual=%h expected=%h", e.req, rd_data, e.rd);
                end
            end else if ({data_full, idle_flag, overrun, held_data, irq} !==
                         {e.full, e.idle, e.ovr, e.data, e.irq}) begin
                errors++;
                $display("FAIL R%0d flags/data/irq actual=%b%b%b %h %b expected=%b%b%b %h %b",
                         e.req, data_full, idle_flag, overrun, held_data, irq,
                         e.full, e.idle, e.ovr, e.data, e.irq);
            end
        end
    end

    task automatic exp_state(input int req, input logic f, input logic i, input logic o,
                             input logic [8:0] d, input logic q);
        exp_t e;
        e = '0;
        e.req = 8'(req); e.full = f; e.idle = i; e.ovr = o; e.data = d; e.irq = q;
        exp_q.push_back(e);
    endtask

    task automatic do_frame(input logic [8:0] d);
        @(negedge clk); frame_stb = 1'b1; frame_data = d;
        @(negedge clk); frame_stb = 1'b0;
    endtask

    task automatic do_rd(input logic sel, input int req, input logic [7:0] want);
        exp_t e;
        @(negedge clk); rd_stb = 1'b1; rd_sel = sel;
        e = '0; e.is_rd = 1'b1; e.req = 8'(req); e.rd = want;
        exp_q.push_back(e);
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic send_bits(input logic v, input int n);
        @(negedge clk); bit_tick = 1'b1; rx_line = v;
        repeat (n) @(negedge clk);
        bit_tick = 1'b0; rx_line = 1'b1;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_state(1, 0, 0, 0, 9'h000, 0);                 // R1 reset state
        send_bits(1'b1, 12); settle();
        exp_state(7, 0, 0, 0, 9'h000, 0);                 // R7 not armed after reset
        do_frame(9'h0A5);
        exp_state(2, 1, 0, 0, 9'h0A5, 0);                 // R2 load; R9 irq still low
        settle();
        exp_state(9, 1, 0, 0, 9'h0A5, 1);                 // R9 irq one cycle later
        do_frame(9'h13C);
        exp_state(8, 1, 0, 1, 9'h0A5, 1);                 // R8 overrun keeps data
        do_rd(1'b1, 4, 8'hA5);
        exp_state(4, 1, 0, 1, 9'h0A5, 1);                 // R4 lone data read
        do_rd(1'b0, 3, 8'h05);                            // R3 status byte
        do_rd(1'b1, 3, 8'hA5);
        settle();
        exp_state(3, 0, 0, 0, 9'h0A5, 0);                 // R3 clear; R9 irq drops
        send_bits(1'b0, 1); send_bits(1'b1, 9); settle();
        exp_state(5, 0, 0, 0, 9'h0A5, 0);                 // R5 nine ones not enough
        send_bits(1'b1, 1); settle();
        exp_state(5, 0, 1, 0, 9'h0A5, 0);                 // R5 tenth one sets idle
        ilie = 1'b1; settle(); settle();
        exp_state(9, 0, 1, 0, 9'h0A5, 1);                 // R9 idle interrupt
        do_rd(1'b0, 3, 8'h02);
        do_rd(1'b1, 3, 8'hA5);
        settle();
        exp_state(3, 0, 0, 0, 9'h0A5, 0);                 // R3 idle cleared
        send_bits(1'b0, 1); send_bits(1'b1, 12); settle();
        exp_state(7, 0, 0, 0, 9'h0A5, 0);                 // R7 no rearm without frame
        do_frame(9'h055);
        do_rd(1'b0, 3, 8'h04);
        do_frame(9'h0EE);
        do_rd(1'b1, 3, 8'h55);
        settle();
        exp_state(3, 0, 0, 1, 9'h055, 1);                 // R3 later overrun survives
        do_rd(1'b0, 3, 8'h01);
        do_rd(1'b1, 3, 8'h55);
        settle();
        exp_state(3, 0, 0, 0, 9'h055, 0);                 // R3 overrun cleared
        fmt9 = 1'b1;
        send_bits(1'b0, 1); send_bits(1'b1, 10); settle();
        exp_state(5, 0, 0, 0, 9'h055, 0);                 // R5 ten ones short in 9-bit
        send_bits(1'b1, 1); settle(); settle();
        exp_state(5, 0, 1, 0, 9'h055, 1);                 // R5 eleventh sets idle
        do_rd(1'b0, 3, 8'h02);
        do_rd(1'b1, 3, 8'h55);
        do_frame(9'h1FF); settle();
        exp_state(2, 1, 0, 0, 9'h1FF, 1);                 // R2 nine-bit word held
        wake_en = 1'b1;
        send_bits(1'b0, 1); send_bits(1'b1, 12); settle();
        exp_state(6, 1, 0, 0, 9'h1FF, 1);                 // R6 wakeup blocks idle
        rie = 1'b0; ilie = 1'b0; settle(); settle();
        exp_state(9, 1, 0, 0, 9'h1FF, 0);                 // R9 enables off
        do_rd(1'b1, 4, 8'hFF); settle();
        exp_state(4, 1, 0, 0, 9'h1FF, 0);                 // R4 flags untouched
        wait (exp_q.size() == 0);
        #5;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule